// File: doc/BRIEF.md
# Indexed Palette RAM Loader

This block is a 256-entry colour lookup table. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. A host loads the table through a small register window. One register selects the entry to start at. A second register takes colour bytes, which are spread over the three components in the fixed order red, green, blue.

A single bus write can carry between one and four component bytes. The loader works out, within the same cycle, which entry and which component each byte lands in. One word can therefore finish one entry and start the next. The entry pointer moves on by itself once a blue byte has been stored.

A scanout engine reads the table through a separate registered lookup port. It presents an 8-bit pixel code and gets back the packed colour one cycle later. Every colour write also raises a redraw request toward the display logic. The display logic clears that request when it has dealt with it.

Top module: `clut_loader`

## Requirements
- R1: After reset, every entry reads back as 0x000000, the next colour byte goes to red, and `redraw_req` is 1.
- R2: A write to offset 0x00 loads `bus_wdata[7:0]` as the current entry index and makes the next colour byte go to red.
- R3: Colour bytes fill red, then green, then blue. After a blue byte the index increments modulo 256 (255 wraps to 0) and the next byte goes to red.
- R4: A colour write at offset 0x04 with `bus_size` = 0 (one byte) stores `bus_wdata[7:0]` as one component byte. The other data bits are ignored.
- R5: A colour write with `bus_size` = 3 (four bytes) stores bytes [31:24], [23:16], [15:8] and [7:0], in that order, as consecutive component bytes. Such a word may complete one entry and continue into the next.
- R6: A colour write with `bus_size` = 1 (two bytes) or 2 (three bytes) stores that many bytes, taken from the top of the word downward starting at [31:24].
- R7: `pix_rgb` presents {red, green, blue} of the entry that `pix_code` selected at the previous rising edge. A write to the same entry in that same cycle returns the old colour. A write to a different entry does not disturb the read.
- R8: `bus_rdata` is zero for the index and colour offsets.
- R9: Every colour write sets `redraw_req`. A `redraw_clr` pulse clears it. If a colour write and `redraw_clr` arrive in the same cycle, the flag stays set.
- R10: Writes to any offset other than 0x00 and 0x04 change neither the table, the index nor the component position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 5 | Byte offset within the 32-byte register window |
| bus_size | input | 2 | Access size minus one (0 = 1 byte ... 3 = 4 bytes) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| redraw_clr | input | 1 | Acknowledge from the display logic, clears `redraw_req` |
| redraw_req | output | 1 | Full-redraw request |
| pix_code | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Looked-up colour {R,G,B}, one cycle after `pix_code` |

## Verification
The bench builds the block with its default parameters: an 8-bit index (256 entries), 8-bit components and four byte lanes. With these values the index wrap from 255 to 0 takes only a single `0xFF` index load to reach. Every start phase can be combined with every access size, so words that straddle two entries are produced from each of the three phases. The 256-entry depth also keeps a reference copy of the whole table small, so any entry can be compared through the lookup port.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam logic [1:0] PH_RED = 2'd0;
  localparam logic [1:0] PH_GRN = 2'd1;
  localparam logic [1:0] PH_BLU = 2'd2;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int LANES   = 4,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [$clog2(LANES)-1:0]       bus_size,
  input  logic [LANES*COMP_W-1:0]        bus_wdata,
  input  logic                           redraw_clr,
  output logic [LANES-1:0]               lane_vld,
  output logic [LANES-1:0][1:0]          lane_comp,
  output logic [LANES-1:0][IDX_W-1:0]    lane_idx,
  output logic [LANES-1:0][COMP_W-1:0]   lane_byte,
  output logic [IDX_W-1:0]               idx_q,
  output logic [1:0]                     phase_q,
  output logic                           redraw_q
);
  localparam int DATA_W = LANES * COMP_W;
  localparam int CNT_W  = $clog2(LANES + 3) + 1;

  logic             idx_wr, map_wr;
  logic [CNT_W-1:0] nbytes, total;
  logic [IDX_W-1:0] idx_d;
  logic [1:0]       phase_d;
  logic             redraw_d;

  assign idx_wr = bus_wr && (bus_addr == ADDR_W'(IDX_OFS));
  assign map_wr = bus_wr && (bus_addr == ADDR_W'(MAP_OFS));
  assign nbytes = CNT_W'(bus_size) + CNT_W'(1);

  // Per-lane placement: lane k lands at (phase + k) counted in components.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [CNT_W-1:0] pos;
      pos          = CNT_W'(phase_q) + CNT_W'(k);
      lane_vld[k]  = map_wr && (CNT_W'(k) < nbytes);
      lane_comp[k] = 2'(pos % CNT_W'(3));
      lane_idx[k]  = idx_q + IDX_W'(pos / CNT_W'(3));
      if (bus_size == '0)
        lane_byte[k] = bus_wdata[COMP_W-1:0];
      else
        lane_byte[k] = bus_wdata[DATA_W-1-k*COMP_W -: COMP_W];
    end
  end

  // Next state for index, phase and redraw flag.
  always_comb begin
    total    = CNT_W'(phase_q) + nbytes;
    idx_d    = idx_q;
    phase_d  = phase_q;
    redraw_d = redraw_q;
    if (idx_wr) begin
      idx_d   = bus_wdata[IDX_W-1:0];
      phase_d = PH_RED;
    end else if (map_wr) begin
      idx_d   = idx_q + IDX_W'(total / CNT_W'(3));
      phase_d = 2'(total % CNT_W'(3));
    end
    if (map_wr)
      redraw_d = 1'b1;
    else if (redraw_clr)
      redraw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      phase_q  <= PH_RED;
      redraw_q <= 1'b1;
    end else begin
      if (idx_wr || map_wr) begin
        idx_q   <= idx_d;
        phase_q <= phase_d;
      end
      redraw_q <= redraw_d;
    end
  end
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int LANES   = 4,
  parameter int COMP_ID = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               lane_vld,
  input  logic [LANES-1:0][1:0]          lane_comp,
  input  logic [LANES-1:0][IDX_W-1:0]    lane_idx,
  input  logic [LANES-1:0][COMP_W-1:0]   lane_byte,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [COMP_W-1:0]              rd_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [COMP_W-1:0] mem [ENTRIES];
  logic [LANES-1:0]  hit;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      hit[k] = lane_vld[k] && (lane_comp[k] == 2'(COMP_ID));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (hit[k]) mem[lane_idx[k]] <= lane_byte[k];
    end
  end

  // Registered lookup: sees the array contents before this edge's writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/clut_loader.sv
module clut_loader #(
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int LANES   = 4,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [$clog2(LANES)-1:0]   bus_size,
  input  logic [LANES*COMP_W-1:0]    bus_wdata,
  output logic [LANES*COMP_W-1:0]    bus_rdata,
  input  logic                       redraw_clr,
  output logic                       redraw_req,
  input  logic [IDX_W-1:0]           pix_code,
  output logic [3*COMP_W-1:0]        pix_rgb
);
  logic [LANES-1:0]             lane_vld;
  logic [LANES-1:0][1:0]        lane_comp;
  logic [LANES-1:0][IDX_W-1:0]  lane_idx;
  logic [LANES-1:0][COMP_W-1:0] lane_byte;
  logic [IDX_W-1:0]             idx_q;
  logic [1:0]                   phase_q;
  logic [2:0][COMP_W-1:0]       comp_rd;

  clut_seq #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .ADDR_W(ADDR_W),
    .LANES(LANES), .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .redraw_clr(redraw_clr),
    .lane_vld(lane_vld), .lane_comp(lane_comp), .lane_idx(lane_idx),
    .lane_byte(lane_byte), .idx_q(idx_q), .phase_q(phase_q),
    .redraw_q(redraw_req)
  );

  for (genvar c = 0; c < 3; c++) begin : g_bank
    clut_bank #(
      .IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES), .COMP_ID(c)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_comp(lane_comp),
      .lane_idx(lane_idx), .lane_byte(lane_byte), .rd_idx(pix_code),
      .rd_data(comp_rd[c])
    );
  end

  assign pix_rgb   = {comp_rd[0], comp_rd[1], comp_rd[2]};
  assign bus_rdata = '0;
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
  parameter int IDX_W   = 8,
  parameter int ADDR_W  = 5,
  parameter int SIZE_W  = 2,
  parameter int DATA_W  = 32,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SIZE_W-1:0] bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              redraw_clr,
  input logic              redraw_req,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        phase_q
);
  logic at_idx, at_map;
  assign at_idx = bus_wr && (bus_addr == ADDR_W'(IDX_OFS));
  assign at_map = bus_wr && (bus_addr == ADDR_W'(MAP_OFS));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_idx |=> (idx_q == $past(bus_wdata[IDX_W-1:0])) && (phase_q == 2'd0));

  p_blue_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_map && bus_size == '0 && phase_q == 2'd2)
      |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (phase_q == 2'd0));

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_map && bus_size == '0 && phase_q != 2'd2)
      |=> $stable(idx_q) && (phase_q == 2'($past(phase_q) + 1'b1)));

  p_redraw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_map |=> redraw_req);

  p_redraw_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_clr && !at_map) |=> !redraw_req);

  p_other_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !at_idx && !at_map) |=> $stable(idx_q) && $stable(phase_q));
endmodule

bind clut_loader clut_loader_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SIZE_W($clog2(LANES)),
  .DATA_W(LANES*COMP_W), .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .redraw_clr(redraw_clr),
  .redraw_req(redraw_req), .idx_q(idx_q), .phase_q(phase_q)
);

// File: tb/clut_loader_bench.sv
module clut_loader_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        redraw_clr;
  logic        redraw_req;
  logic [7:0]  pix_code;
  logic [23:0] pix_rgb;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_ph;

  always #(CLK_P/2) clk = ~clk;

  clut_loader u_clut_loader (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .redraw_clr(redraw_clr), .redraw_req(redraw_req),
    .pix_code(pix_code), .pix_rgb(pix_rgb)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference placement of colour bytes, taken from the requirements.
  task automatic model_map(input logic [1:0] sz, input logic [31:0] d);
    for (int k = 0; k <= int'(sz); k++) begin
      logic [7:0] b;
      b = (sz == 2'd0) ? d[7:0] : d[31-8*k -: 8];
      case (m_ph)
        0: m_r[m_idx] = b;
        1: m_g[m_idx] = b;
        default: m_b[m_idx] = b;
      endcase
      m_ph++;
      if (m_ph == 3) begin m_ph = 0; m_idx++; end
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [1:0] sz,
                           input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    if (a == 5'h00) begin m_idx = d[7:0]; m_ph = 0; end
    else if (a == 5'h04) model_map(sz, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] code, input string req);
    @(negedge clk);
    pix_code = code;
    @(posedge clk); #1;
    check(pix_rgb == {m_r[code], m_g[code], m_b[code]}, req,
          {8'h0, pix_rgb}, {8'h0, m_r[code], m_g[code], m_b[code]});
  endtask

  task automatic t_reset;
    check(redraw_req == 1'b1, "R1 redraw after reset", {31'h0, redraw_req}, 1);
    lookup(8'd0, "R1 entry 0 clear");
    lookup(8'd128, "R1 entry 128 clear");
    lookup(8'd255, "R1 entry 255 clear");
    bus_write(5'h04, 2'd0, 32'h0000_005A); // first byte goes to red of entry 0
    lookup(8'd0, "R1 phase starts at red");
  endtask

  task automatic t_single;
    bus_write(5'h00, 2'd0, 32'h0000_000A);
    bus_write(5'h04, 2'd0, 32'hAB00_0011);
    bus_write(5'h04, 2'd0, 32'hCD00_0022);
    bus_write(5'h04, 2'd0, 32'hEF00_0033);
    bus_write(5'h04, 2'd0, 32'h1200_0044);
    lookup(8'd10, "R4 single bytes fill entry 10");
    lookup(8'd11, "R3 index advanced after blue");
  endtask

  task automatic t_word;
    bus_write(5'h00, 2'd0, 32'd20);
    bus_write(5'h04, 2'd3, 32'hA1B2_C3D4);
    bus_write(5'h04, 2'd3, 32'h0102_0304);
    lookup(8'd20, "R5 word fills entry 20");
    lookup(8'd21, "R5 word spans into entry 21");
    lookup(8'd22, "R5 second word reaches entry 22");
    bus_write(5'h04, 2'd3, 32'h9192_9394); // start phase blue
    lookup(8'd22, "R5 word from blue phase, entry 22");
    lookup(8'd23, "R5 word from blue phase, entry 23");
  endtask

  task automatic t_partial;
    bus_write(5'h00, 2'd0, 32'd30);
    bus_write(5'h04, 2'd1, 32'h5566_EEEE);
    bus_write(5'h04, 2'd2, 32'h7788_99EE);
    lookup(8'd30, "R6 two then three bytes, entry 30");
    lookup(8'd31, "R6 three-byte tail, entry 31");
  endtask

  task automatic t_wrap;
    bus_write(5'h00, 2'd0, 32'h0000_00FF);
    bus_write(5'h04, 2'd2, 32'hF0F1_F2AA);
    bus_write(5'h04, 2'd0, 32'hAB00_000E);
    lookup(8'd255, "R3 entry 255 filled");
    lookup(8'd0, "R3 index wraps 255 to 0");
  endtask

  task automatic t_index_rephase;
    bus_write(5'h00, 2'd0, 32'd40);
    bus_write(5'h04, 2'd0, 32'h0000_0012);
    bus_write(5'h00, 2'd0, 32'd40);
    bus_write(5'h04, 2'd0, 32'h0000_0034);
    lookup(8'd40, "R2 index write returns phase to red");
    lookup(8'd41, "R2 entry 41 untouched");
  endtask

  task automatic t_ignore;
    bus_write(5'h00, 2'd0, 32'd50);
    bus_write(5'h10, 2'd3, 32'hDEAD_BEEF);
    bus_write(5'h08, 2'd0, 32'h0000_0099);
    bus_write(5'h01, 2'd0, 32'h0000_0077);
    lookup(8'd50, "R10 other offsets leave entry 50");
    bus_write(5'h04, 2'd0, 32'h0000_0077);
    lookup(8'd50, "R10 index and phase kept");
    lookup(8'd51, "R10 entry 51 untouched");
  endtask

  task automatic t_redraw;
    @(negedge clk); redraw_clr = 1'b1;
    @(negedge clk); redraw_clr = 1'b0;
    check(redraw_req == 1'b0, "R9 clear drops request", {31'h0, redraw_req}, 0);
    bus_write(5'h04, 2'd0, 32'h0);
    check(redraw_req == 1'b1, "R9 colour write sets request", {31'h0, redraw_req}, 1);
    @(negedge clk); redraw_clr = 1'b1;
    @(negedge clk); redraw_clr = 1'b0;
    check(redraw_req == 1'b0, "R9 clear again", {31'h0, redraw_req}, 0);
    @(negedge clk);
    redraw_clr = 1'b1; bus_wr = 1'b1; bus_addr = 5'h04; bus_size = 2'd0;
    bus_wdata = 32'h0;
    model_map(2'd0, 32'h0);
    @(negedge clk);
    redraw_clr = 1'b0; bus_wr = 1'b0;
    check(redraw_req == 1'b1, "R9 set wins over clear", {31'h0, redraw_req}, 1);
    bus_write(5'h00, 2'd0, 32'd5);
    check(redraw_req == 1'b1, "R9 index write keeps request", {31'h0, redraw_req}, 1);
  endtask

  task automatic t_collide;
    logic [23:0] old60, old10;
    bus_write(5'h00, 2'd0, 32'd60);
    bus_write(5'h04, 2'd2, 32'h6162_63FF);
    bus_write(5'h00, 2'd0, 32'd60);
    old60 = {m_r[60], m_g[60], m_b[60]};
    old10 = {m_r[10], m_g[10], m_b[10]};
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h04; bus_size = 2'd0; bus_wdata = 32'h99;
    pix_code = 8'd60;
    model_map(2'd0, 32'h99);
    @(posedge clk); #1;
    check(pix_rgb == old60, "R7 same-entry read returns old colour",
          {8'h0, pix_rgb}, {8'h0, old60});
    @(negedge clk);
    bus_wdata = 32'h98; pix_code = 8'd10;
    model_map(2'd0, 32'h98);
    @(posedge clk); #1;
    check(pix_rgb == old10, "R7 other-entry read undisturbed",
          {8'h0, pix_rgb}, {8'h0, old10});
    @(negedge clk); bus_wr = 1'b0;
    lookup(8'd60, "R7 new colour visible next cycle");
  endtask

  task automatic t_rdata;
    @(negedge clk); bus_addr = 5'h00; #1;
    check(bus_rdata == 32'h0, "R8 index offset reads zero", bus_rdata, 0);
    @(negedge clk); bus_addr = 5'h04; #1;
    check(bus_rdata == 32'h0, "R8 colour offset reads zero", bus_rdata, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_size = '0;
    bus_wdata = '0; redraw_clr = 1'b0; pix_code = '0;
    for (int e = 0; e < 256; e++) begin m_r[e] = 0; m_g[e] = 0; m_b[e] = 0; end
    m_idx = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_word();
    t_partial();
    t_wrap();
    t_index_rephase();
    t_ignore();
    t_redraw();
    t_collide();
    t_rdata();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule